// File: doc/BRIEF.md
# Programmable Feedback Divider with Transmit/Receive Offset

This block is the feedback divider of a frequency synthesizer loop. It runs on the oscillator-side clock and produces a one-cycle pulse once every N clock cycles, where N is chosen by a 14-bit parallel division word. A transmit/receive select input picks between two values of N. With the select high, N is the raw word. With the select low, a fixed offset of 856 is added to the word. This lets a transceiver move its oscillator by an intermediate-frequency step without changing the programmed word.

The ratio path has three stages. The sum of word and offset is formed at 15 bits and clamps at the largest 14-bit value. A floor stage raises any ratio below 2 to 2. A down-counter holds the remaining count; it reloads the ratio when it reaches zero and marks each reload with the output pulse.

The block has no input pull-ups. A board that leaves inputs unconnected, or that keeps their defaults, drives all ones with the select high. That gives an unoffset ratio of 16383.

Top module: `prog_divider_offset`

## Requirements
- R1: With `tx_rx_sel` high, the effective ratio N equals `div_word`, where bit 0 is the least significant bit and bit 13 the most significant. `div_pulse` rises once every N clock cycles.
- R2: With `tx_rx_sel` low, N equals `div_word` + 856. For example, word 5 gives a period of 861 and word 100 gives a period of 956.
- R3: The offset sum does not wrap. Any sum above 16383 is clamped to 16383. Word 15527 with the offset gives 16383 exactly, and word 15600 with the offset also gives 16383.
- R4: An effective ratio of 0 or 1 is raised to 2. Words 0, 1 and 2 with the select high all give a period of 2; word 3 gives a period of 3.
- R5: `div_pulse` is high for exactly one clock cycle on each reload and is low in every other cycle.
- R6: N is sampled only at a reload. A change of `div_word` or `tx_rx_sel` in the middle of a count leaves the current period unchanged, and the new ratio governs the next period.
- R7: Reset is synchronous and active low (`rst_n`). While it is sampled low, `div_pulse` is 0 and the counter loads the current effective ratio. After release, the first pulse appears at the N-th rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-side clock that is divided |
| rst_n | input | 1 | Synchronous reset, active low |
| div_word | input | 14 | Parallel division word |
| tx_rx_sel | input | 1 | High: no offset. Low: add 856 |
| div_pulse | output | 1 | One-cycle pulse on each reload |

## Verification
A pulse is registered. A reload decided at rising edge k shows `div_pulse` high from edge k until edge k+1. The bench therefore samples every output at the falling edge after the edge that produced it. A behavioural model counts down the cycles to the next pulse and is compared with `div_pulse` at every falling edge.

The model samples a new ratio at the same edge as the design's reload. Input changes are made at falling edges, so the effect of a mid-count change (R6) is due one full period after the next reload. The directed period checks wait for one reload before they measure, and the first-pulse check after reset counts exactly N falling edges from release.

// File: rtl/divsyn_pkg.sv
// Package divsyn_pkg
// Shared defaults and types for the feedback divider.
// Assumes the offset is smaller than the largest ratio.
package divsyn_pkg;
    localparam int DIV_WORD_W   = 14;
    localparam int DIV_OFFSET   = 856;
    localparam int DIV_MIN_N    = 2;

    typedef logic [DIV_WORD_W-1:0] div_word_t;
endpackage

// File: rtl/div_offset_adder.sv
// Module div_offset_adder
// Adds a fixed offset to the division word when enabled and clamps the
// result to the largest W-bit value instead of letting it wrap.
// Assumes OFFSET < 2**W. Purely combinational.
module div_offset_adder #(
    parameter int W      = 14,
    parameter int OFFSET = 856
) (
    input  logic [W-1:0] word_in,
    input  logic         add_en,
    output logic [W-1:0] sum_out
);
    localparam logic [W:0]   OFF_V = (W+1)'(OFFSET);
    localparam logic [W-1:0] SAT_V = {W{1'b1}};

    generate
        if (OFFSET == 0) begin : g_no_offset
            // Purpose: no offset configured, pass the word straight through
            always_comb sum_out = word_in;
        end else begin : g_offset
            logic [W:0] wide_sum;
            // Purpose: widen, add the offset, clamp on carry out
            always_comb begin
                wide_sum = {1'b0, word_in} + (add_en ? OFF_V : '0);
                sum_out  = wide_sum[W] ? SAT_V : wide_sum[W-1:0];
            end
        end
    endgenerate
endmodule

// File: rtl/div_ratio_floor.sv
// Module div_ratio_floor
// Raises any ratio below MIN_N to MIN_N so the counter never stalls.
// Assumes MIN_N >= 2 and MIN_N < 2**W. Purely combinational.
module div_ratio_floor #(
    parameter int W     = 14,
    parameter int MIN_N = 2
) (
    input  logic [W-1:0] ratio_in,
    output logic [W-1:0] ratio_out
);
    localparam logic [W-1:0] MIN_V = W'(MIN_N);

    // Purpose: clamp small ratios up to the minimum
    always_comb ratio_out = (ratio_in < MIN_V) ? MIN_V : ratio_in;
endmodule

// File: rtl/div_down_counter.sv
// Module div_down_counter
// Counts the remaining cycles down to zero. At zero it reloads N-1 and
// raises the pulse for one cycle, so the period is exactly N.
// Assumes ratio_n >= MIN_N >= 2. Reset is synchronous and active low.
module div_down_counter #(
    parameter int W     = 14,
    parameter int MIN_N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ratio_n,
    output logic         pulse
);
    logic [W-1:0] count;
    logic [W-1:0] reload_v;

    // Purpose: the preset value is one less than the ratio
    always_comb reload_v = ratio_n - W'(1);

    // Purpose: decrement, reload at terminal count, flag the reload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= reload_v;
            pulse <= 1'b0;
        end else if (count == '0) begin
            count <= reload_v;
            pulse <= 1'b1;
        end else begin
            count <= count - W'(1);
            pulse <= 1'b0;
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse); // R5
    AST_COUNT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (count != '0) |=> (count == $past(count) - W'(1))); // R6
    AST_RELOAD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> (count >= W'(MIN_N - 1))); // R4
    AST_PULSE_AFTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |=> pulse); // R1
endmodule

// File: rtl/prog_divider_offset.sv
// Module prog_divider_offset
// Feedback divider for a synthesizer loop. The ratio is the division
// word, plus a fixed offset when tx_rx_sel is low, clamped at both ends.
// The counter samples the ratio only at a reload.
// Assumes a single clock domain for the inputs.
module prog_divider_offset
    import divsyn_pkg::*;
#(
    parameter int W      = DIV_WORD_W,
    parameter int OFFSET = DIV_OFFSET,
    parameter int MIN_N  = DIV_MIN_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] div_word,
    input  logic         tx_rx_sel,
    output logic         div_pulse
);
    logic [W-1:0] n_sum;
    logic [W-1:0] n_eff;

    div_offset_adder #(.W(W), .OFFSET(OFFSET)) i_adder (
        .word_in (div_word),
        .add_en  (!tx_rx_sel),
        .sum_out (n_sum)
    );

    div_ratio_floor #(.W(W), .MIN_N(MIN_N)) i_floor (
        .ratio_in  (n_sum),
        .ratio_out (n_eff)
    );

    div_down_counter #(.W(W), .MIN_N(MIN_N)) i_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .ratio_n (n_eff),
        .pulse   (div_pulse)
    );

    AST_SUM_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        n_sum >= div_word); // R3
    AST_RAW_WHEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_rx_sel && div_word >= W'(MIN_N)) |-> (n_eff == div_word)); // R1
    AST_RATIO_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        n_eff >= W'(MIN_N)); // R4
endmodule

// File: tb/test_prog_divider_offset.sv
module test_prog_divider_offset;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] div_word = 14'h3FFF;
    logic        tx_rx_sel = 1'b1;
    logic        div_pulse;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    string cur_req = "R7";

    int m_left  = 0;
    bit m_pulse = 0;

    prog_divider_offset i_prog_divider_offset (
        .clk(clk), .rst_n(rst_n), .div_word(div_word),
        .tx_rx_sel(tx_rx_sel), .div_pulse(div_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Ratio taken from the requirements (R1 to R4)
    function automatic int eff_n(input int w, input bit sel);
        int s;
        s = w + (sel ? 0 : 856);
        if (s > 16383) s = 16383;
        if (s < 2) s = 2;
        return s;
    endfunction

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Behavioural model: cycles remaining until the next pulse
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_left  = eff_n(div_word, tx_rx_sel);
            m_pulse = 0;
        end else begin
            m_left--;
            if (m_left == 0) begin
                m_pulse = 1;
                m_left  = eff_n(div_word, tx_rx_sel);
            end else begin
                m_pulse = 0;
            end
        end
        if (cycles > WDOG_LIMIT) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WDOG_LIMIT);
            summary();
        end
    end

    // Compare with the model on every falling edge
    always @(negedge clk) begin
        checks++;
        if (div_pulse !== m_pulse) begin
            errors++;
            $display("FAIL %s model: actual %b expected %b at cycle %0d",
                     cur_req, div_pulse, m_pulse, cycles);
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_pulse();
        do @(negedge clk); while (div_pulse !== 1'b1);
    endtask

    // Waits for a reload, then measures the following period
    task automatic measure(input string req, input int exp);
        int gap;
        cur_req = req;
        wait_pulse();
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
            if (gap == 1) check("R5", int'(div_pulse), 0);
        end while (div_pulse !== 1'b1);
        check(req, gap, exp);
    endtask

    initial begin
        // R7: reset state and the first pulse after release
        div_word = 14'd10;
        repeat (3) @(negedge clk);
        check("R7", int'(div_pulse), 0);
        rst_n = 1'b1;
        for (int i = 1; i <= 10; i++) begin
            @(negedge clk);
            check("R7", int'(div_pulse), (i == 10) ? 1 : 0);
        end
        measure("R1", 10);
        // R2: offset when the select is low
        tx_rx_sel = 1'b0; div_word = 14'd5;
        measure("R2", 861);
        div_word = 14'd100;
        measure("R2", 956);
        // R4: small ratios
        tx_rx_sel = 1'b1; div_word = 14'd0;
        measure("R4", 2);
        div_word = 14'd1;
        measure("R4", 2);
        div_word = 14'd2;
        measure("R4", 2);
        div_word = 14'd3;
        measure("R4", 3);
        // R6: a mid-count change waits for the next reload
        div_word = 14'd20;
        measure("R6", 20);
        cur_req = "R6";
        wait_pulse();
        repeat (3) @(negedge clk);
        div_word = 14'd7;
        begin
            int rest = 3;
            while (div_pulse !== 1'b1) begin @(negedge clk); rest++; end
            check("R6", rest, 20);
        end
        measure("R6", 7);
        // R3: clamping of the sum
        tx_rx_sel = 1'b0; div_word = 14'd15527;
        measure("R3", 16383);
        div_word = 14'd15600;
        measure("R3", 16383);
        // R7: reset in the middle of a count
        tx_rx_sel = 1'b1; div_word = 14'd4;
        cur_req = "R7";
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R7", int'(div_pulse), 0);
        rst_n = 1'b1;
        for (int i = 1; i <= 4; i++) begin
            @(negedge clk);
            check("R7", int'(div_pulse), (i == 4) ? 1 : 0);
        end
        measure("R1", 4);
        summary();
    end
endmodule